// File: doc/BRIEF.md
# Three-Slot Opcode Issue Sequencer

This block sits between the instruction memory port and the opcode decoder of a small stack processor. Every instruction word is 18 bits wide and carries up to three 5-bit opcodes. When memory signals that a word is ready, the sequencer captures it and hands the opcodes to the decoder one at a time. It starts with the most significant field.

A 3-bit one-hot selector marks the field being issued. Consecutive fields are spaced by a fixed gap of `SLOT_GAP` clock cycles. Issue ends after the third field. It ends earlier when the opcode just issued transfers control or touches data memory. At that point the block raises a one-cycle fetch request so that the next word can be obtained, and it waits for the next ready strobe. A ready strobe that arrives while a word is still being issued is ignored.

Top module: `slot_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `op_valid`, `fetch_req`, `op_slot` and `op_code` are all zero.
- R2: A `word_rdy` sampled high while the block is idle causes `op_valid=1`, `op_slot=3'b001` and `op_code=word_in[17:13]` in the following cycle.
- R3: If issue continues, `op_code=word[12:8]` with `op_slot=3'b010` is issued `SLOT_GAP` cycles after the first field, and `op_code=word[7:3]` with `op_slot=3'b100` is issued `SLOT_GAP` cycles after that.
- R4: Bits 2:0 of the word are never issued and have no effect on any output.
- R5: After the field with `op_slot=3'b100` is issued, `op_valid` stays low until a new `word_rdy` is accepted. `fetch_req` is high in the same cycle as that last field.
- R6: The opcodes 0x00, 0x01, 0x02, 0x03, 0x06, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D and 0x0F end issue at the field that carries them. That cycle has `fetch_req=1`, and no later field of the word is issued.
- R7: Any other opcode in the first or second field lets issue continue, with `fetch_req=0` in its cycle.
- R8: A `word_rdy` sampled while a word is still being issued is ignored, together with the `word_in` value that accompanies it. The current sequence continues unchanged, and no extra field is issued.
- R9: `op_valid` is high only in the cycles in which a field is issued. `op_slot` has at most one bit set, and `fetch_req` is never high without `op_valid`.
- R10: A `word_rdy` sampled in the cycle in which `fetch_req` is high is accepted, so a new first field is issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_rdy | input | 1 | Memory strobe: `word_in` holds a new instruction word |
| word_in | input | 18 | Instruction word with three opcode fields |
| op_valid | output | 1 | One-cycle pulse: `op_code` holds a newly issued opcode |
| op_code | output | 5 | Opcode issued to the decoder |
| op_slot | output | 3 | One-hot index of the field being issued |
| fetch_req | output | 1 | Issue of the current word has ended; request the next word |

## Verification
The first field of a word appears in the cycle after the edge that samples `word_rdy`. Field k appears `k*SLOT_GAP` cycles after that, and `fetch_req` is high in the same cycle as the field that ends issue. The bench drives its inputs on the falling edge. It samples on the following falling edge, which is exactly one register stage later, and then counts whole cycles from there. In every cycle between issues it checks that `op_valid` and `fetch_req` are low. It runs this check while random ready strobes and random words are applied, so ignored strobes are observed at the ports. The gap in the bench is 3 rather than the default.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    localparam int WORD_W = 18;
    localparam int OP_W   = 5;
    localparam int SLOTS  = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OP_W-1:0]   opcode_t;
    typedef logic [SLOTS-1:0]  slot_sel_t;

    // Opcodes that end issue of the current word
    typedef enum logic [OP_W-1:0] {
        OP_JMP    = 5'h00,
        OP_BRZ    = 5'h01,
        OP_CALL   = 5'h02,
        OP_BRNEG  = 5'h03,
        OP_RET    = 5'h06,
        OP_LDR    = 5'h08,
        OP_LDAINC = 5'h09,
        OP_LIT    = 5'h0A,
        OP_LDA    = 5'h0B,
        OP_STR    = 5'h0C,
        OP_STAINC = 5'h0D,
        OP_STA    = 5'h0F
    } stop_op_e;

    // Field k occupies the k-th group of OP_W bits counted from the MSB
    function automatic opcode_t pick_field(word_t w, slot_sel_t sel);
        opcode_t r;
        r = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (sel[k]) r = w[WORD_W-1-k*OP_W -: OP_W];
        end
        return r;
    endfunction

    function automatic logic ends_issue(opcode_t op);
        case (op)
            OP_JMP, OP_BRZ, OP_CALL, OP_BRNEG, OP_RET,
            OP_LDR, OP_LDAINC, OP_LIT, OP_LDA,
            OP_STR, OP_STAINC, OP_STA: return 1'b1;
            default:                   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/slot_gap_timer.sv
module slot_gap_timer #(
    parameter int SLOT_GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int CW = (SLOT_GAP > 1) ? $clog2(SLOT_GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(SLOT_GAP - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

    // R3: the count never exceeds the programmed gap
    p_gap_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= RELOAD);

    // R3: a reload leaves exactly SLOT_GAP-1 cycles to wait
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == RELOAD);
endmodule

// File: rtl/slot_shifter.sv
module slot_shifter
    import slot_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      advance,
    output slot_sel_t next_sel,
    output slot_sel_t sel
);
    always_comb begin
        if (start)        next_sel = slot_sel_t'(1);
        else if (advance) next_sel = {sel[SLOTS-2:0], 1'b0};
        else              next_sel = sel;
    end

    always_ff @(posedge clk) begin
        if (rst)                  sel <= '0;
        else if (start | advance) sel <= next_sel;
    end

    // R9: selector is never more than one-hot
    p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R3: an advance from the first field moves to the second
    p_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (advance && !start && sel[0]) |=> sel[1]);
endmodule

// File: rtl/slot_stop_decode.sv
module slot_stop_decode
    import slot_seq_pkg::*;
(
    input  opcode_t   op,
    input  slot_sel_t sel,
    output logic      stop
);
    logic last_field;
    logic op_stop;

    assign last_field = sel[SLOTS-1];
    assign op_stop    = ends_issue(op);
    assign stop       = last_field | op_stop;
endmodule

// File: rtl/slot_seq.sv
module slot_seq
    import slot_seq_pkg::*;
#(
    parameter int SLOT_GAP = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        word_rdy,
    input  logic [17:0] word_in,
    output logic        op_valid,
    output logic [4:0]  op_code,
    output logic [2:0]  op_slot,
    output logic        fetch_req
);
    logic      busy;
    logic      expire;
    logic      start;
    logic      advance;
    logic      issue;
    logic      stop;
    word_t     word_q;
    word_t     src_word;
    slot_sel_t next_sel;
    slot_sel_t cur_sel;
    opcode_t   cur_op;

    assign start    = word_rdy & ~busy;
    assign advance  = busy & expire;
    assign issue    = start | advance;
    assign src_word = busy ? word_q : word_in;
    assign cur_op   = pick_field(src_word, next_sel);

    slot_gap_timer #(.SLOT_GAP(SLOT_GAP)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (issue),
        .run    (busy),
        .expire (expire)
    );

    slot_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .advance  (advance),
        .next_sel (next_sel),
        .sel      (cur_sel)
    );

    slot_stop_decode u_stop (
        .op   (cur_op),
        .sel  (next_sel),
        .stop (stop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            word_q    <= '0;
            op_valid  <= 1'b0;
            op_code   <= '0;
            fetch_req <= 1'b0;
        end else begin
            op_valid  <= issue;
            fetch_req <= issue & stop;
            if (start) word_q <= word_in;
            if (issue) begin
                op_code <= cur_op;
                busy    <= ~stop;
            end
        end
    end

    assign op_slot = cur_sel;

    // R2: an accepted strobe issues the first field next cycle
    p_start_slot0_r2: assert property (@(posedge clk) disable iff (rst)
        (word_rdy && !busy) |=> (op_valid && op_slot == 3'b001));

    // R5: the last field always raises the fetch request
    p_last_halts_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_slot[2]) |-> fetch_req);

    // R9: no fetch request without an issued field
    p_fetch_valid_r9: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> op_valid);

    // R8: while waiting out the gap, nothing is issued whatever the strobe
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !expire) |=> !op_valid);

    // R5: once halted, no field is issued without a new strobe
    p_stay_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !word_rdy) |=> !op_valid);
endmodule

// File: tb/slot_seq_bench.sv
module slot_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_rdy = 1'b0;
    logic [17:0] word_in = '0;
    logic        op_valid;
    logic [4:0]  op_code;
    logic [2:0]  op_slot;
    logic        fetch_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_seq #(.SLOT_GAP(GAP)) u_slot_seq (
        .clk       (clk),
        .rst       (rst),
        .word_rdy  (word_rdy),
        .word_in   (word_in),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_slot   (op_slot),
        .fetch_req (fetch_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit stops(input logic [4:0] op);
        return op inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h06, 5'h08,
                          5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0F};
    endfunction

    function automatic logic [4:0] field(input logic [17:0] w, input int k);
        return 5'((w >> (13 - 5*k)) & 18'h1F);
    endfunction

    function automatic int last_field(input logic [17:0] w);
        for (int k = 0; k < 2; k++) if (stops(field(w, k))) return k;
        return 2;
    endfunction

    // Drive a word, then follow its whole issue sequence cycle by cycle
    task automatic run_word(input logic [17:0] w, input bit noise, input string tag);
        int n;
        int k;
        string ct;
        string ft;
        n = last_field(w);
        word_rdy = 1'b1;
        word_in  = w;
        @(negedge clk);
        ct = (tag != "") ? tag : "R2";
        ft = (n == 0) ? "R6" : "R7";
        chk(op_valid == 1'b1, ct, "first valid", int'(op_valid), 1);
        chk(op_slot == 3'b001, ct, "first slot", int'(op_slot), 1);
        chk(op_code == field(w, 0), ct, "first code", int'(op_code), int'(field(w, 0)));
        chk(fetch_req == (n == 0), ft, "first fetch", int'(fetch_req), int'(n == 0));
        for (int c = 1; c <= n*GAP; c++) begin
            word_rdy = noise ? 1'($urandom % 2) : 1'b0;
            word_in  = noise ? 18'($urandom) : w;
            @(negedge clk);
            if (c % GAP == 0) begin
                k  = c / GAP;
                ct = (tag != "") ? tag : "R3";
                ft = (k == 2) ? "R5" : (k == n ? "R6" : "R7");
                chk(op_valid == 1'b1, ct, "valid", int'(op_valid), 1);
                chk(op_slot == 3'(1 << k), ct, "slot", int'(op_slot), 1 << k);
                chk(op_code == field(w, k), ct, "code", int'(op_code), int'(field(w, k)));
                chk(fetch_req == (k == n), ft, "fetch", int'(fetch_req), int'(k == n));
            end else begin
                ct = noise ? "R8" : "R9";
                chk(op_valid == 1'b0, ct, "gap valid", int'(op_valid), 0);
                chk(fetch_req == 1'b0, ct, "gap fetch", int'(fetch_req), 0);
            end
        end
        word_rdy = 1'b0;
    endtask

    task automatic idle_check(input int cycles);
        word_rdy = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(op_valid == 1'b0, "R5", "idle valid", int'(op_valid), 0);
            chk(fetch_req == 1'b0, "R5", "idle fetch", int'(fetch_req), 0);
        end
    endtask

    initial begin
        logic [4:0] stop_list [12];
        int unsigned seed;
        stop_list = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h06, 5'h08,
                      5'h09, 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0F};
        seed = $urandom(32'd1234);

        // R1: reset state, with a strobe applied during reset
        word_rdy = 1'b1;
        word_in  = 18'h3FFFF;
        repeat (3) @(negedge clk);
        chk(op_valid == 1'b0, "R1", "reset valid", int'(op_valid), 0);
        chk(fetch_req == 1'b0, "R1", "reset fetch", int'(fetch_req), 0);
        chk(op_slot == 3'b000, "R1", "reset slot", int'(op_slot), 0);
        chk(op_code == 5'h00, "R1", "reset code", int'(op_code), 0);
        word_rdy = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(op_valid == 1'b0, "R1", "post-reset valid", int'(op_valid), 0);

        // All three fields run, then stay halted
        run_word({5'h1E, 5'h1E, 5'h1E, 3'b000}, 1'b0, "");
        idle_check(GAP + 3);
        run_word({5'h10, 5'h11, 5'h12, 3'b101}, 1'b0, "");
        idle_check(2);

        // R4: low bits differ, issued codes follow only the upper fields
        run_word({5'h14, 5'h17, 5'h1B, 3'b111}, 1'b0, "R4");
        idle_check(1);
        run_word({5'h14, 5'h17, 5'h1B, 3'b010}, 1'b0, "R4");
        idle_check(1);

        // R6: every stopping opcode in the first and in the second field
        foreach (stop_list[i]) begin
            run_word({stop_list[i], 5'h1E, 5'h1E, 3'b011}, 1'b0, "");
            idle_check(GAP + 1);
            run_word({5'h1F, stop_list[i], 5'h1E, 3'b000}, 1'b0, "");
            idle_check(2);
        end

        // R8: strobes and junk words while busy
        run_word({5'h1E, 5'h1A, 5'h17, 3'b000}, 1'b1, "R8");
        idle_check(2);

        // R10: strobe in the fetch-request cycle is accepted
        run_word({5'h1E, 5'h1E, 5'h1E, 3'b000}, 1'b0, "");
        run_word({5'h02, 5'h1E, 5'h1E, 3'b000}, 1'b0, "R10");
        run_word({5'h1C, 5'h09, 5'h00, 3'b000}, 1'b0, "R10");
        idle_check(1);

        // Random words, random busy strobes, random idle gaps
        for (int i = 0; i < 400; i++) begin
            logic [17:0] w;
            w = 18'($urandom);
            run_word(w, 1'($urandom % 2), "");
            if ($urandom % 3 == 0) idle_check(1 + int'($urandom % 3));
        end
        idle_check(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule